// File: doc/BRIEF.md
# Predicated Vector Element Mode Unit

This block runs one two-source integer operation (add or subtract on 16-bit elements) across a short vector, one element per clock. A per-element predicate mask and a 5-bit mode field set how each element is treated. In plain element-wise mode, masked elements can be skipped, written with zero, or computed from zeroed sources. In saturating mode, results clamp to the signed or unsigned range instead of wrapping. In folding mode, the active elements are combined into one scalar, which is placed in the lowest active lane. In predicate-result mode, each result's condition nibble is tested, and a failed test masks that element.

A caller drives the operands and controls and pulses `start_i` while the unit is idle. The operand arrays must stay stable while `busy_o` is high. The destination array, its per-lane write strobes, the condition array and its strobes are valid while `done_o` is high, and they hold until the next accepted start. Control walks three states. IDLE goes to RUN when `start_i` is sampled high. RUN handles one element per cycle and goes to DONE on the last element. DONE lasts one cycle and returns to IDLE.

Top module: `pvec_mode_unit`

## Requirements
- R1: Mode field layout is as follows. `mode_i[1:0]` selects the kind: 00 element-wise (bit 2 ignored), 01 saturating (bit 2 = 1 signed, 0 unsigned), 10 folding, 11 predicate-result (bit 2 = invert). `mode_i[3]` is source-zeroing and `mode_i[4]` is destination-zeroing, except in predicate-result mode with `rc_i`=1, where both flags read as 0.
- R2: `start_i` is accepted only in IDLE. Acceptance latches the controls and clears `dst_we_o` and `cr_we_o`. `busy_o` is then high for exactly N cycles, where N is the clamped vector length. `done_o` is high for one cycle right after the last busy cycle. A `start_i` seen while busy has no effect.
- R3: An active element (predicate bit 1) in element-wise mode writes lane i with a[i]+b[i], or a[i]−b[i] when `sub_i`=1, wrapping modulo 2^16. Its `dst_we_o` bit is set.
- R4: For a masked element outside folding mode, the first matching rule applies. Source-zeroing set: the element is computed with both sources equal to zero, like an active one. Else destination-zeroing set: the lane is written with 0 and no condition is written. Else the lane is not written.
- R5: The condition nibble of lane i is placed at `cr_o[4i+3:4i]` as {lt, gt, eq, ov}. lt, gt and eq are taken from the written result read as signed. ov is the signed overflow of the wrapping operation. The nibble and its `cr_we_o` bit are written for every computed element exactly when `rc_i`=1.
- R6: Signed saturation replaces an overflowing result with 0x7FFF when the first source is non-negative and with 0x8000 when it is negative.
- R7: Unsigned saturation gives 0xFFFF on an add carry and 0x0000 on a subtract borrow.
- R8: Folding starts from a[f] and then applies `op b[j]` for every active lane j in ascending order, where f is the lowest active lane. The result (and its nibble when `rc_i`=1) is written only to lane f. Zeroing flags are ignored in this mode.
- R9: Folding with no active lane inside the vector writes no lane and no condition.
- R10: Predicate-result mode tests nibble bit k. k is `mode_i[4:3]` when `rc_i`=1 (0=ov, 1=eq, 2=gt, 3=lt) and 1 (eq) when `rc_i`=0. The test passes when that bit differs from the invert flag. A passing element writes its result.
- R11: A failed test is treated as a masked element. With `rc_i`=1 the lane is not written, but its condition nibble still is. With `rc_i`=0 the lane gets 0 if destination-zeroing is set and is skipped otherwise.
- R12: Lanes at or above the vector length are never written. A `vl_i` of 0 acts as 1, and values above 8 act as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (idle only) |
| mode_i | input | 5 | Mode field |
| rc_i | input | 1 | Record condition results |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| vl_i | input | 4 | Vector length |
| pred_i | input | 8 | Predicate mask, bit i for lane i |
| src_a_i | input | 128 | First source elements, lane i at [16i+15:16i] |
| src_b_i | input | 128 | Second source elements |
| busy_o | output | 1 | Elements being processed |
| done_o | output | 1 | One-cycle completion pulse |
| dst_o | output | 128 | Destination elements |
| dst_we_o | output | 8 | Lane written this operation |
| cr_o | output | 32 | Condition nibbles |
| cr_we_o | output | 8 | Nibble written this operation |

## Verification
The hardest state to reach from the ports is a predicate-result failure that must still leave a condition nibble behind, because the test result itself is never visible. The stimulus gets there with a constant first source minus a rising second source. This sends the results through positive, zero and negative values, so the gt test passes on some lanes and fails on others in a single pass. Folding is driven with scattered masks whose lowest active lane is not lane 0, and a second start is pulsed mid-run to show it is ignored.

// File: rtl/pvec_pkg.sv
package pvec_pkg;
    localparam int ELEM_W_DEF = 16;
    localparam int MAX_VL_DEF = 8;
    localparam int CRW        = 4;
    localparam int CR_LT      = 3;
    localparam int CR_GT      = 2;
    localparam int CR_EQ      = 1;
    localparam int CR_OV      = 0;

    typedef enum logic [1:0] {
        MODE_ELEM = 2'b00,
        MODE_SAT  = 2'b01,
        MODE_FOLD = 2'b10,
        MODE_PRES = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_e;
endpackage

// File: rtl/pvec_elem_alu.sv
module pvec_elem_alu
    import pvec_pkg::*;
#(
    parameter int W = ELEM_W_DEF
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           sub_i,
    input  logic           sat_i,
    input  logic           sgn_i,
    output logic [W-1:0]   res_o,
    output logic [CRW-1:0] cr_o
);
    logic [W:0]   wide;
    logic [W-1:0] wrap;
    logic         s_ovf;
    logic         u_ovf;

    always_comb begin
        wide  = sub_i ? ({1'b0, a_i} - {1'b0, b_i}) : ({1'b0, a_i} + {1'b0, b_i});
        wrap  = wide[W-1:0];
        u_ovf = wide[W];
        if (sub_i) s_ovf = (a_i[W-1] != b_i[W-1]) && (wrap[W-1] != a_i[W-1]);
        else       s_ovf = (a_i[W-1] == b_i[W-1]) && (wrap[W-1] != a_i[W-1]);
        res_o = wrap;
        if (sat_i) begin
            if (sgn_i && s_ovf)
                res_o = a_i[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
            else if (!sgn_i && u_ovf)
                res_o = sub_i ? '0 : '1;
        end
        cr_o[CR_LT] = res_o[W-1];
        cr_o[CR_GT] = !res_o[W-1] && (res_o != '0);
        cr_o[CR_EQ] = (res_o == '0);
        cr_o[CR_OV] = s_ovf;
    end

    // clamped results never move against the operation's direction
    always_comb begin
        if (sat_i && !sgn_i) begin
            if (!sub_i) p_usat_add_mono_r7: assert (res_o >= a_i);
            else        p_usat_sub_mono_r7: assert (res_o <= a_i);
        end
        if (sat_i && sgn_i && !sub_i && !b_i[W-1])
            p_ssat_add_mono_r6: assert ($signed(res_o) >= $signed(a_i));
    end
endmodule

// File: rtl/pvec_pres_test.sv
module pvec_pres_test
    import pvec_pkg::*;
(
    input  logic [CRW-1:0] cr_i,
    input  logic           rc_i,
    input  logic [1:0]     sel_i,
    input  logic           inv_i,
    output logic           pass_o
);
    logic [1:0] bit_sel;

    always_comb begin
        bit_sel = rc_i ? sel_i : 2'(CR_EQ);
        pass_o  = cr_i[bit_sel] ^ inv_i;
    end
endmodule

// File: rtl/pvec_mode_unit.sv
module pvec_mode_unit
    import pvec_pkg::*;
#(
    parameter int ELEM_W = ELEM_W_DEF,
    parameter int MAX_VL = MAX_VL_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [4:0]                 mode_i,
    input  logic                       rc_i,
    input  logic                       sub_i,
    input  logic [$clog2(MAX_VL+1)-1:0] vl_i,
    input  logic [MAX_VL-1:0]          pred_i,
    input  logic [MAX_VL*ELEM_W-1:0]   src_a_i,
    input  logic [MAX_VL*ELEM_W-1:0]   src_b_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [MAX_VL*ELEM_W-1:0]   dst_o,
    output logic [MAX_VL-1:0]          dst_we_o,
    output logic [MAX_VL*CRW-1:0]      cr_o,
    output logic [MAX_VL-1:0]          cr_we_o
);
    localparam int VLW  = $clog2(MAX_VL + 1);
    localparam int IDXW = $clog2(MAX_VL);

    state_e state_q, state_d;

    logic [IDXW-1:0]          idx_q, last_q, first_q, last_d, fold_idx;
    logic [4:0]               mode_q;
    logic                     rc_q, sub_q, found_q;
    logic [MAX_VL-1:0]        pred_q;
    logic [ELEM_W-1:0]        acc_q;
    logic [CRW-1:0]           cr_acc_q;
    logic [MAX_VL*ELEM_W-1:0] dst_q;
    logic [MAX_VL-1:0]        dst_we_q, cr_we_q;
    logic [MAX_VL*CRW-1:0]    cr_q;
    logic [VLW-1:0]           vl_clamp;

    mode_e             kind;
    logic              is_fold, pres_rc, sz, dz, pbit, zsrc, live, keep, pass, is_last;
    logic [ELEM_W-1:0] a_el, b_el, op_a, op_b, alu_res;
    logic [CRW-1:0]    alu_cr;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (is_last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy_o   = (state_q == ST_RUN);
        done_o   = (state_q == ST_DONE);
        dst_o    = dst_q;
        dst_we_o = dst_we_q;
        cr_o     = cr_q;
        cr_we_o  = cr_we_q;
    end

    // ---------------- element decode ----------------
    always_comb begin
        if (vl_i == '0)                 vl_clamp = VLW'(1);
        else if (vl_i > VLW'(MAX_VL))   vl_clamp = VLW'(MAX_VL);
        else                            vl_clamp = vl_i;
        last_d   = IDXW'(vl_clamp - VLW'(1));
        kind     = mode_e'(mode_q[1:0]);
        is_fold  = (kind == MODE_FOLD);
        pres_rc  = (kind == MODE_PRES) && rc_q;
        sz       = !pres_rc && mode_q[3];
        dz       = !pres_rc && mode_q[4];
        pbit     = pred_q[idx_q];
        is_last  = (idx_q == last_q);
        a_el     = src_a_i[idx_q*ELEM_W +: ELEM_W];
        b_el     = src_b_i[idx_q*ELEM_W +: ELEM_W];
        zsrc     = !pbit && sz && !is_fold;
        live     = pbit || zsrc;
        if (is_fold)   op_a = found_q ? acc_q : a_el;
        else if (zsrc) op_a = '0;
        else           op_a = a_el;
        op_b     = zsrc ? '0 : b_el;
        keep     = live && ((kind != MODE_PRES) || pass);
        fold_idx = found_q ? first_q : idx_q;
    end

    pvec_elem_alu #(.W(ELEM_W)) u_alu (
        .a_i(op_a), .b_i(op_b), .sub_i(sub_q),
        .sat_i(kind == MODE_SAT), .sgn_i(mode_q[2]),
        .res_o(alu_res), .cr_o(alu_cr)
    );

    pvec_pres_test u_test (
        .cr_i(alu_cr), .rc_i(rc_q), .sel_i(mode_q[4:3]),
        .inv_i(mode_q[2]), .pass_o(pass)
    );

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0; last_q <= '0; first_q <= '0; found_q <= 1'b0;
            mode_q <= '0; rc_q <= 1'b0; sub_q <= 1'b0; pred_q <= '0;
            acc_q <= '0; cr_acc_q <= '0;
            dst_q <= '0; dst_we_q <= '0; cr_q <= '0; cr_we_q <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            idx_q <= '0; last_q <= last_d; found_q <= 1'b0;
            mode_q <= mode_i; rc_q <= rc_i; sub_q <= sub_i; pred_q <= pred_i;
            dst_we_q <= '0; cr_we_q <= '0;
        end else if (state_q == ST_RUN) begin
            idx_q <= idx_q + 1'b1;
            if (is_fold) begin
                if (pbit) begin
                    acc_q    <= alu_res;
                    cr_acc_q <= alu_cr;
                    if (!found_q) begin
                        found_q <= 1'b1;
                        first_q <= idx_q;
                    end
                end
                if (is_last && (pbit || found_q)) begin
                    dst_q[fold_idx*ELEM_W +: ELEM_W] <= pbit ? alu_res : acc_q;
                    dst_we_q[fold_idx] <= 1'b1;
                    if (rc_q) begin
                        cr_q[fold_idx*CRW +: CRW] <= pbit ? alu_cr : cr_acc_q;
                        cr_we_q[fold_idx] <= 1'b1;
                    end
                end
            end else begin
                if (keep) begin
                    dst_q[idx_q*ELEM_W +: ELEM_W] <= alu_res;
                    dst_we_q[idx_q] <= 1'b1;
                end else if (dz) begin
                    dst_q[idx_q*ELEM_W +: ELEM_W] <= '0;
                    dst_we_q[idx_q] <= 1'b1;
                end
                if (live && rc_q) begin
                    cr_q[idx_q*CRW +: CRW] <= alu_cr;
                    cr_we_q[idx_q] <= 1'b1;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));
    p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (dst_we_o == '0 && cr_we_o == '0));
    p_lane_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((dst_we_o >> (int'(last_q) + 1)) == '0));
    p_fold_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && is_fold) |-> ($countones(dst_we_o) <= 1));
    p_cr_needs_rc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !rc_q) |-> (cr_we_o == '0));
endmodule

// File: tb/pvec_mode_unit_bench.sv
module pvec_mode_unit_bench;
    typedef struct packed {
        logic [4:0]  mode;
        logic        rc;
        logic        sub;
        logic [3:0]  vl;
        logic [7:0]  pred;
        logic [15:0] a0, da, b0, db;
        logic [7:0]  exp_we;
        logic [7:0]  exp_crwe;
    } vec_t;

    localparam int NROWS = 11;
    localparam vec_t TABLE [NROWS] = '{
        '{5'b00000, 1'b1, 1'b0, 4'd8,  8'hFF,       16'd100,  16'd3, 16'd7,  16'd11, 8'hFF, 8'hFF}, // R3 R5
        '{5'b00000, 1'b0, 1'b1, 4'd5,  8'b10110101, 16'd50,   16'd1, 16'd60, 16'd2,  8'h15, 8'h00}, // R3 R4 skip
        '{5'b10000, 1'b1, 1'b0, 4'd6,  8'b00001001, 16'd5,    16'd1, 16'd9,  16'd1,  8'h3F, 8'h09}, // R4 dz
        '{5'b01000, 1'b1, 1'b0, 4'd4,  8'h05,       16'd20,   16'd1, 16'd30, 16'd1,  8'h0F, 8'h0F}, // R4 sz
        '{5'b00101, 1'b1, 1'b0, 4'd8,  8'hFF,       16'h7FF0, 16'd4, 16'd8,  16'd1,  8'hFF, 8'hFF}, // R6
        '{5'b00001, 1'b0, 1'b1, 4'd8,  8'hFF,       16'd4,    16'd1, 16'd6,  16'd0,  8'hFF, 8'h00}, // R7
        '{5'b00010, 1'b1, 1'b0, 4'd8,  8'b01101000, 16'd10,   16'd1, 16'd100,16'd10, 8'h08, 8'h08}, // R8
        '{5'b10011, 1'b1, 1'b1, 4'd8,  8'hFF,       16'd3,    16'd0, 16'd0,  16'd1,  8'h07, 8'hFF}, // R10 R11
        '{5'b00111, 1'b0, 1'b1, 4'd4,  8'hFF,       16'd2,    16'd0, 16'd0,  16'd1,  8'h0B, 8'h00}, // R10 R11
        '{5'b00000, 1'b1, 1'b0, 4'd0,  8'hFF,       16'd1,    16'd1, 16'd1,  16'd1,  8'h01, 8'h01}, // R12
        '{5'b00000, 1'b0, 1'b0, 4'd12, 8'hFF,       16'd1,    16'd1, 16'd1,  16'd1,  8'hFF, 8'h00}  // R12
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [4:0]   mode = '0;
    logic         rc = 1'b0;
    logic         sub = 1'b0;
    logic [3:0]   vl = '0;
    logic [7:0]   pred = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         busy, done;
    logic [127:0] dst;
    logic [7:0]   dst_we, cr_we;
    logic [31:0]  cr;

    int n_checks = 0;
    int n_fail   = 0;
    int busy_cnt = 0;

    logic [15:0] ed [8];
    logic [3:0]  ec [8];
    logic [7:0]  ew, ecw;

    always #5 clk = ~clk;

    pvec_mode_unit u_pvec_mode_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .rc_i(rc),
        .sub_i(sub), .vl_i(vl), .pred_i(pred), .src_a_i(src_a), .src_b_i(src_b),
        .busy_o(busy), .done_o(done), .dst_o(dst), .dst_we_o(dst_we),
        .cr_o(cr), .cr_we_o(cr_we)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] nib(input logic [15:0] r, input logic ov);
        return {r[15], !r[15] && (r != 0), r == 0, ov};
    endfunction

    // reference built from the requirement text
    task automatic model();
        int n, full, first;
        logic [15:0] x, y, r, acc;
        logic [3:0] c, cacc;
        logic ov, szf, dzf, prc, found, ok;
        n = (vl == 0) ? 1 : ((vl > 8) ? 8 : int'(vl));
        ew = '0; ecw = '0; found = 1'b0; first = 0; acc = '0; cacc = '0;
        for (int i = 0; i < 8; i++) begin ed[i] = '0; ec[i] = '0; end
        prc = (mode[1:0] == 2'b11) && rc;
        szf = !prc && mode[3];
        dzf = !prc && mode[4];
        for (int i = 0; i < n; i++) begin
            x = src_a[i*16 +: 16]; y = src_b[i*16 +: 16];
            if (mode[1:0] == 2'b10) begin
                if (pred[i]) begin
                    if (!found) begin acc = x; first = i; found = 1'b1; end
                    full = sub ? $signed(acc) - $signed(y) : $signed(acc) + $signed(y);
                    ov = (full > 32767) || (full < -32768);
                    acc = sub ? acc - y : acc + y;
                    cacc = nib(acc, ov);
                end
                continue;
            end
            if (!pred[i] && !szf) begin
                if (dzf) begin ed[i] = '0; ew[i] = 1'b1; end
                continue;
            end
            if (!pred[i]) begin x = '0; y = '0; end
            full = sub ? $signed(x) - $signed(y) : $signed(x) + $signed(y);
            ov = (full > 32767) || (full < -32768);
            r = sub ? x - y : x + y;
            if (mode[1:0] == 2'b01) begin
                if (mode[2]) begin
                    if (full > 32767) r = 16'h7FFF;
                    else if (full < -32768) r = 16'h8000;
                end else begin
                    full = sub ? int'(x) - int'(y) : int'(x) + int'(y);
                    if (full > 65535) r = 16'hFFFF;
                    else if (full < 0) r = 16'h0000;
                end
            end
            c = nib(r, ov);
            ok = (mode[1:0] != 2'b11) || (c[rc ? int'(mode[4:3]) : 1] != mode[2]);
            if (rc) begin ec[i] = c; ecw[i] = 1'b1; end
            if (ok) begin ed[i] = r; ew[i] = 1'b1; end
            else if (dzf) begin ed[i] = '0; ew[i] = 1'b1; end
        end
        if (found) begin
            ed[first] = acc; ew[first] = 1'b1;
            if (rc) begin ec[first] = cacc; ecw[first] = 1'b1; end
        end
    endtask

    // start an operation and wait for done; optional second start mid-run
    task automatic run_op(input bit poke);
        int guard = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_cnt = 0;
        while (!done && guard < 100) begin
            if (busy) busy_cnt++;
            if (poke && busy_cnt == 2) begin
                start = 1'b1; mode = 5'b00010; rc = ~rc;
            end else start = 1'b0;
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        if (guard >= 100) check("R2 done timeout", 32'd0, 32'd1);
    endtask

    task automatic load_row(input vec_t v);
        mode = v.mode; rc = v.rc; sub = v.sub; vl = v.vl; pred = v.pred;
        for (int i = 0; i < 8; i++) begin
            src_a[i*16 +: 16] = v.a0 + 16'(i) * v.da;
            src_b[i*16 +: 16] = v.b0 + 16'(i) * v.db;
        end
    endtask

    task automatic compare(input string tag, input vec_t v);
        int n;
        n = (v.vl == 0) ? 1 : ((v.vl > 8) ? 8 : int'(v.vl));
        check({tag, " R2 busy cycles"}, busy_cnt, n);
        check({tag, " we mask"}, {24'd0, dst_we}, {24'd0, v.exp_we});
        check({tag, " R5 cr_we mask"}, {24'd0, cr_we}, {24'd0, v.exp_crwe});
        check({tag, " model we"}, {24'd0, dst_we}, {24'd0, ew});
        for (int i = 0; i < 8; i++) begin
            if (ew[i]) check({tag, " lane data"}, {16'd0, dst[i*16 +: 16]}, {16'd0, ed[i]});
            if (ecw[i]) check({tag, " R5 lane cr"}, {28'd0, cr[i*4 +: 4]}, {28'd0, ec[i]});
        end
    endtask

    function automatic string row_tag(input int k);
        case (k)
            0: return "R3 add";
            1: return "R4 skip";
            2: return "R4 dz";
            3: return "R4 sz";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            7: return "R10 R11 rc";
            8: return "R11 norc";
            9: return "R12 vl0";
            default: return "R12 vlbig";
        endcase
    endfunction

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R2)
        check("R2 reset busy", {31'd0, busy}, 32'd0);
        check("R2 reset done", {31'd0, done}, 32'd0);
        check("R2 reset we", {24'd0, dst_we}, 32'd0);
        check("R2 reset cr_we", {24'd0, cr_we}, 32'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NROWS; k++) begin
            load_row(TABLE[k]);
            model();
            run_op(1'b0);
            compare(row_tag(k), TABLE[k]);
        end

        // R1 / R6 literal: lane 2 clamps to max, nibble gt+ov
        load_row(TABLE[4]); run_op(1'b0);
        check("R6 lane2 clamp", {16'd0, dst[47:32]}, 32'h7FFF);
        check("R1 R6 lane2 cr", {28'd0, cr[11:8]}, 32'h5);
        // R7 literal: 4-6 borrows to zero
        load_row(TABLE[5]); run_op(1'b0);
        check("R7 lane0 clamp", {16'd0, dst[15:0]}, 32'h0);
        // R8 literal: 13+130+150+160 = 453 at lane 3
        load_row(TABLE[6]); run_op(1'b0);
        check("R8 fold value", {16'd0, dst[63:48]}, 32'd453);
        check("R8 fold cr", {28'd0, cr[15:12]}, 32'h4);
        // R9: folding with empty mask inside vl
        load_row(TABLE[6]); pred = 8'hF0; vl = 4'd4; run_op(1'b0);
        check("R9 no write", {24'd0, dst_we}, 32'd0);
        check("R9 no cr", {24'd0, cr_we}, 32'd0);
        // R2: start while busy is ignored
        load_row(TABLE[0]); model(); run_op(1'b1);
        compare("R2 mid-run start ignored", TABLE[0]);
        check("R2 idle after", {31'd0, busy}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule